// File: doc/BRIEF.md
# Random Victim Slot Selector

This block picks a translation-buffer slot to overwrite when a new mapping must be installed and no particular slot is preferred. A pulse on the request input advances a 32-bit linear congruential generator by one step. The upper half of the new generator value is then reduced to a slot number that lies in the replaceable part of the buffer. Slots below a programmable wired boundary hold pinned mappings and are never returned.

The reduction uses a remainder unit that handles one dividend bit per cycle. Each selection therefore takes a fixed number of cycles. The result appears on a registered index output together with a one-cycle valid pulse. The buffer size is a parameter of at most 64 slots. The wired boundary is a 6-bit input, and it is captured at the moment a request is accepted.

Top module: `rnd_victim_sel`

## Requirements
- R1: The generator holds a 32-bit value that changes only on an accepted request. On each accepted request it becomes value * 314159 + 1, wrapped to 32 bits.
- R2: Synchronous active-high reset returns the generator value to zero. The first index after reset is therefore computed from the value 1.
- R3: With W the captured wired count and N = TLB_SIZE, the index equals ((new_value >> 16) mod (N − W)) + W, where new_value is the generator value after the step caused by the same request.
- R4: When W < N, every index satisfies W ≤ index ≤ N − 1.
- R5: When W ≥ N, the index equals W. This is the defined fallback.
- R6: `idx_vld` is high for exactly one cycle. It rises 17 clock edges after the edge that accepts the request, and `idx` is valid while it is high.
- R7: A request that arrives while a selection is in progress has no effect. It does not advance the generator and does not produce an extra valid pulse.
- R8: The wired count is sampled on the accepting edge. Changes on `wired` during a selection do not alter its result.
- R9: While reset is applied, `idx_vld` and `idx` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe for a new victim slot |
| wired | input | 6 | Number of pinned slots at the bottom of the buffer |
| idx | output | 6 | Selected slot number |
| idx_vld | output | 1 | One-cycle pulse marking a fresh `idx` |

## Verification
A wrong generator value cannot be seen directly. It shows up as an index that departs from the predicted sequence, and at the latest this happens on the second selection after reset, because the first selection always returns W. A remainder unit that takes an off-by-one number of steps, or skips a subtraction, gives an index outside the replaceable range or one that differs from the model in that same selection. A busy guard that does not hold shifts every later index in the sequence. A capture of W on the wrong edge makes the index follow a `wired` value that was changed mid-selection.

// File: rtl/rnd_victim_pkg.sv
package rnd_victim_pkg;
  localparam int          IDX_W     = 6;
  localparam int          LCG_W     = 32;
  localparam int          DRAW_W    = 16;
  localparam logic [31:0] LCG_MUL   = 32'd314159;
  localparam logic [31:0] LCG_INC   = 32'd1;
  typedef logic [IDX_W-1:0] slot_t;
endpackage

// File: rtl/rnd_victim_lcg.sv
module rnd_victim_lcg
  import rnd_victim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [DRAW_W-1:0] draw
);
  logic [LCG_W-1:0] lcg_q;
  logic [LCG_W-1:0] lcg_d;

  // next value, wrapped to LCG_W bits
  assign lcg_d = LCG_W'(lcg_q * LCG_MUL + LCG_INC);
  // the reduction works on the upper half of the freshly stepped value
  assign draw  = lcg_d[LCG_W-1 -: DRAW_W];

  always_ff @(posedge clk) begin
    if (rst)       lcg_q <= '0;
    else if (step) lcg_q <= lcg_d;
  end
endmodule

// File: rtl/rnd_victim_modred.sv
module rnd_victim_modred #(
  parameter int DW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [RW-1:0] divisor,
  output logic [RW-1:0] rem,
  output logic          done
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh_q;
  logic [RW-1:0] dv_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [RW:0]   trial;
  logic          fits;

  // restoring step: bring in the next dividend bit, subtract when possible
  assign trial = {rem, sh_q[DW-1]};
  assign fits  = (trial >= {1'b0, dv_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      dv_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      rem   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh_q  <= dividend;
        dv_q  <= divisor;
        cnt_q <= '0;
        rem   <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem   <= fits ? RW'(trial - {1'b0, dv_q}) : trial[RW-1:0];
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(DW - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rnd_victim_sel.sv
module rnd_victim_sel
  import rnd_victim_pkg::*;
#(
  parameter int TLB_SIZE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] wired,
  output logic [IDX_W-1:0] idx,
  output logic             idx_vld
);
  localparam int               RW    = $clog2(TLB_SIZE + 1);
  localparam logic [IDX_W:0]   NSLOT = (IDX_W + 1)'(TLB_SIZE);

  logic              busy;
  logic              accept;
  logic              fb_now;
  logic              fb_q;
  slot_t             wired_q;
  logic [IDX_W:0]    span;
  logic [RW-1:0]     divisor;
  logic [DRAW_W-1:0] draw;
  logic [RW-1:0]     rem;
  logic              rem_done;

  assign accept  = req & ~busy;
  assign fb_now  = ({1'b0, wired} >= NSLOT);
  assign span    = NSLOT - {1'b0, wired};
  assign divisor = fb_now ? RW'(1) : RW'(span);

  rnd_victim_lcg u_lcg (
    .clk  (clk),
    .rst  (rst),
    .step (accept),
    .draw (draw)
  );

  rnd_victim_modred #(.DW(DRAW_W), .RW(RW)) u_mod (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .dividend (draw),
    .divisor  (divisor),
    .rem      (rem),
    .done     (rem_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      wired_q <= '0;
      fb_q    <= 1'b0;
      idx     <= '0;
      idx_vld <= 1'b0;
    end else begin
      idx_vld <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        wired_q <= wired;
        fb_q    <= fb_now;
      end else if (rem_done) begin
        busy    <= 1'b0;
        idx_vld <= 1'b1;
        idx     <= fb_q ? wired_q : slot_t'(IDX_W'(rem) + wired_q);
      end
    end
  end
endmodule

// File: rtl/rnd_victim_sel_chk.sv
module rnd_victim_sel_chk #(
  parameter int TLB_SIZE = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       idx_vld,
  input logic [5:0] idx,
  input logic [5:0] wired_q
);
  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    idx_vld |=> !idx_vld);
  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_vld && (int'(wired_q) < TLB_SIZE)) |-> (idx >= wired_q && int'(idx) < TLB_SIZE));
  // R5
  idx_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_vld && (int'(wired_q) >= TLB_SIZE)) |-> (idx == wired_q));
  // R9
  vld_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!idx_vld && idx == 6'd0));
endmodule

module rnd_victim_lcg_chk (
  input logic        clk,
  input logic        rst,
  input logic        step,
  input logic [31:0] lcg_q
);
  // R2
  lcg_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lcg_q == 32'd0));
  // R1
  lcg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(lcg_q));
endmodule

bind rnd_victim_sel rnd_victim_sel_chk #(.TLB_SIZE(TLB_SIZE)) u_sel_chk (
  .clk(clk), .rst(rst), .idx_vld(idx_vld), .idx(idx), .wired_q(wired_q));

bind rnd_victim_lcg rnd_victim_lcg_chk u_lcg_chk (
  .clk(clk), .rst(rst), .step(step), .lcg_q(lcg_q));

// File: tb/test_rnd_victim_sel.sv
`timescale 1ns/1ps
module test_rnd_victim_sel;
  localparam int N   = 16;
  localparam int LAT = 17;
  localparam int NV  = 12;
  // stimulus vectors: wired count; expected index comes from the model below
  localparam int unsigned WV [NV] = '{0, 3, 15, 7, 1, 0, 12, 16, 20, 5, 14, 63};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [5:0] wired = '0;
  logic [5:0] idx;
  logic       idx_vld;

  int checks = 0;
  int errors = 0;
  logic [31:0] mstate = 32'd0;

  always #2 clk = ~clk;

  rnd_victim_sel #(.TLB_SIZE(N)) i_rnd_victim_sel (
    .clk(clk), .rst(rst), .req(req), .wired(wired), .idx(idx), .idx_vld(idx_vld));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int model_step(input int unsigned w);
    int unsigned hi;
    mstate = mstate * 32'd314159 + 32'd1;
    hi = mstate >> 16;
    if (w >= N) return int'(w);
    return int'(hi % (N - w) + w);
  endfunction

  // one selection; optional busy-time request and wired change
  task automatic run_one(input int unsigned w, input bit poke, input string rq);
    int exp;
    int cyc;
    exp = model_step(w);
    @(negedge clk); wired = 6'(w); req = 1'b1;
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    wired = 6'((w + 9) % 64);                      // R8: changed mid-selection
    cyc = 0;
    while (!idx_vld && cyc < 100) begin
      if (poke && cyc == 5) req = 1'b1;             // R7: ignored request
      if (poke && cyc == 6) req = 1'b0;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    req = 1'b0;
    chk(cyc == LAT, "R6 latency", cyc, LAT);
    chk(int'(idx) == exp, {rq, " R3/R8 index"}, int'(idx), exp);
    if (w < N) chk(idx >= w && int'(idx) < N, "R4 range", int'(idx), int'(w));
    else       chk(int'(idx) == int'(w), "R5 fallback", int'(idx), int'(w));
    @(posedge clk); @(negedge clk);
    chk(!idx_vld, "R6 single pulse", int'(idx_vld), 0);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!idx_vld, "R9 vld in reset", int'(idx_vld), 0);
    chk(idx == 6'd0, "R9 idx in reset", int'(idx), 0);
    rst = 1'b0;

    // R2: first draw after reset comes from value 1, so index equals wired
    run_one(5, 1'b0, "R2 first");
    for (int i = 0; i < NV; i++) run_one(WV[i], 1'b0, "R1 table");

    // R7: request while busy must not advance the generator
    run_one(2, 1'b1, "R7 poke");
    repeat (25) begin
      @(negedge clk);
      chk(!idx_vld, "R7 no extra pulse", int'(idx_vld), 0);
    end
    run_one(4, 1'b0, "R7 after poke");

    // R2: reset mid-sequence returns generator to zero
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!idx_vld && idx == 6'd0, "R9 reset again", int'(idx), 0);
    rst = 1'b0;
    mstate = 32'd0;
    run_one(9, 1'b0, "R2 restart");
    run_one(0, 1'b0, "R2 restart second");
    run_one(15, 1'b0, "R4 top edge");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule